// File: doc/BRIEF.md
# Variable-Size Single-Entry Translation Buffer

This block caches the most recent successful virtual-to-physical mapping for each of three access kinds: instruction fetch, data read and data write. Each channel keeps its own single entry. The entry stores a tag, a frame and the mask of the mapping it came from. That lets one comparison cover a 1 MB section, a 64 KB large page, a 4 KB small page or a 1 KB tiny page. A lookup is purely combinational. On a hit the physical address is the stored frame joined with the untranslated low bits of the virtual address.

The table walker and the permission checker fill an entry after a translation. The fill only takes effect when the domain outcome allows caching: a manager domain, or a client domain whose permission check passed. A per-channel invalidate input empties an entry.

When translation is switched off by the enable input, every channel reports a hit and passes the virtual address through unchanged.

Top module: `xlat_buf`

## Requirements
- R1: After synchronous reset every entry is empty, so with translation enabled every lookup misses.
- R2: After a permitted fill, a lookup hits when its address lies in the mapped region. The physical address is then (fill physical address AND mask) OR (lookup address AND NOT mask). The size codes and their masks are: 0 = 0xFFF00000 (section), 1 = 0xFFFF0000 (large), 2 = 0xFFFFF000 (small), 3 = 0xFFFFFC00 (tiny).
- R3: A lookup whose masked address differs from the stored tag misses.
- R4: The fill is gated by the domain code. The codes are 0 = no access, 1 = client, 2 = reserved, 3 = manager. Only code 3, or code 1 with the permission-ok input high, updates the entry. Any other fill leaves the previous contents, valid or not, unchanged.
- R5: Channels 0 (fetch), 1 (read) and 2 (write) are independent. A fill or invalidate on one channel leaves the lookups of the others unchanged.
- R6: Invalidate empties the entry at the next clock edge. It wins over a fill to the same channel in the same cycle.
- R7: With the enable input low, every channel reports a hit and its physical address equals its virtual address, whatever the entry holds.
- R8: A fill takes effect only at the clock edge. Before that edge, a lookup reflects the old contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mmu_en | input | 1 | Translation enable; low means identity mapping |
| lk_vaddr | input | NCH x 32 | Per-channel lookup virtual address |
| lk_hit | output | NCH | Per-channel hit (forced high when disabled) |
| lk_paddr | output | NCH x 32 | Per-channel physical address |
| fill_valid | input | NCH | Per-channel fill request |
| fill_vaddr | input | 32 | Virtual address of the translated access |
| fill_paddr | input | 32 | Physical address of the translated access |
| fill_size | input | 2 | Mapping size code |
| fill_dom | input | 2 | Domain outcome code |
| fill_perm_ok | input | 1 | Client permission check passed |
| inval | input | NCH | Per-channel invalidate |

## Verification
A fill and an invalidate can land on the same channel in the same cycle. The sweep raises both together on a regular share of its fills, each time with a domain code that would otherwise be cached. The checks then require that channel to miss at the filled address. Every other lookup in the sweep is judged against an arithmetic model of the three entries, and this model also confirms that the gated fill and the invalidate on one channel do not disturb the other two.

// File: rtl/xb_pkg.sv
package xb_pkg;
    localparam int XB_AW          = 32;
    localparam int XB_OFF_SECTION = 20;
    localparam int XB_OFF_LARGE   = 16;
    localparam int XB_OFF_SMALL   = 12;
    localparam int XB_OFF_TINY    = 10;

    typedef enum logic [1:0] {
        SZ_SECTION = 2'd0,
        SZ_LARGE   = 2'd1,
        SZ_SMALL   = 2'd2,
        SZ_TINY    = 2'd3
    } map_size_e;

    typedef enum logic [1:0] {
        DOM_DENY    = 2'd0,
        DOM_CLIENT  = 2'd1,
        DOM_RSVD    = 2'd2,
        DOM_MANAGER = 2'd3
    } dom_class_e;

    typedef struct packed {
        logic [XB_AW-1:0] vaddr;
        logic [XB_AW-1:0] paddr;
        logic [XB_AW-1:0] mask;
    } fill_req_t;

    function automatic logic [XB_AW-1:0] size_mask(map_size_e sz);
        logic [XB_AW-1:0] ones;
        ones = {XB_AW{1'b1}};
        case (sz)
            SZ_SECTION: size_mask = ones << XB_OFF_SECTION;
            SZ_LARGE:   size_mask = ones << XB_OFF_LARGE;
            SZ_SMALL:   size_mask = ones << XB_OFF_SMALL;
            default:    size_mask = ones << XB_OFF_TINY;
        endcase
    endfunction
endpackage

// File: rtl/xb_fill_gate.sv
module xb_fill_gate
    import xb_pkg::*;
(
    input  logic       req,
    input  dom_class_e dom,
    input  logic       perm_ok,
    output logic       allow
);
    always_comb begin
        case (dom)
            DOM_MANAGER: allow = req;
            DOM_CLIENT:  allow = req & perm_ok;
            default:     allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/xb_entry.sv
module xb_entry
    import xb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load,
    input  fill_req_t        req,
    input  logic [XB_AW-1:0] look_va,
    output logic             hit,
    output logic [XB_AW-1:0] look_pa
);
    logic             valid_q;
    logic [XB_AW-1:0] tag_q;
    logic [XB_AW-1:0] frame_q;
    logic [XB_AW-1:0] offm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
            frame_q <= '0;
            offm_q  <= '0;
        end else if (clear) begin
            valid_q <= 1'b0;
        end else if (load) begin
            valid_q <= 1'b1;
            tag_q   <= req.vaddr & req.mask;
            frame_q <= req.paddr & req.mask;
            offm_q  <= ~req.mask;
        end
    end

    always_comb begin
        hit     = valid_q && ((look_va & ~offm_q) == tag_q);
        look_pa = frame_q | (look_va & offm_q);
    end
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
    import xb_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       mmu_en,
    input  logic [NCH-1:0][XB_AW-1:0]  lk_vaddr,
    output logic [NCH-1:0]             lk_hit,
    output logic [NCH-1:0][XB_AW-1:0]  lk_paddr,
    input  logic [NCH-1:0]             fill_valid,
    input  logic [XB_AW-1:0]           fill_vaddr,
    input  logic [XB_AW-1:0]           fill_paddr,
    input  logic [1:0]                 fill_size,
    input  logic [1:0]                 fill_dom,
    input  logic                       fill_perm_ok,
    input  logic [NCH-1:0]             inval
);
    fill_req_t req;

    always_comb begin
        req.vaddr = fill_vaddr;
        req.paddr = fill_paddr;
        req.mask  = size_mask(map_size_e'(fill_size));
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic             allow;
        logic             e_hit;
        logic [XB_AW-1:0] e_pa;

        xb_fill_gate u_gate (
            .req     (fill_valid[c]),
            .dom     (dom_class_e'(fill_dom)),
            .perm_ok (fill_perm_ok),
            .allow   (allow)
        );

        xb_entry u_ent (
            .clk     (clk),
            .rst     (rst),
            .clear   (inval[c]),
            .load    (allow),
            .req     (req),
            .look_va (lk_vaddr[c]),
            .hit     (e_hit),
            .look_pa (e_pa)
        );

        always_comb begin
            lk_hit[c]   = mmu_en ? e_hit : 1'b1;
            lk_paddr[c] = mmu_en ? e_pa  : lk_vaddr[c];
        end
    end
endmodule

// File: rtl/xlat_buf_chk.sv
module xlat_buf_chk
    import xb_pkg::*;
#(
    parameter int NCH = 3
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       mmu_en,
    input logic [NCH-1:0][XB_AW-1:0]  lk_vaddr,
    input logic [NCH-1:0]             lk_hit,
    input logic [NCH-1:0][XB_AW-1:0]  lk_paddr,
    input logic [NCH-1:0]             inval
);
    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R1
        reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(rst) |-> !(mmu_en && lk_hit[c]));
        // R2
        offset_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (mmu_en && lk_hit[c]) |->
                (lk_paddr[c][XB_OFF_TINY-1:0] == lk_vaddr[c][XB_OFF_TINY-1:0]));
        // R6
        inval_empty_chk: assert property (@(posedge clk) disable iff (rst)
            inval[c] |=> !(mmu_en && lk_hit[c]));
        // R7
        bypass_ident_chk: assert property (@(posedge clk) disable iff (rst)
            !mmu_en |-> (lk_hit[c] && lk_paddr[c] == lk_vaddr[c]));
    end
endmodule

bind xlat_buf xlat_buf_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mmu_en   (mmu_en),
    .lk_vaddr (lk_vaddr),
    .lk_hit   (lk_hit),
    .lk_paddr (lk_paddr),
    .inval    (inval)
);

// File: tb/sim_xlat_buf.sv
`timescale 1ns/1ps
module sim_xlat_buf;
    localparam int NCH = 3;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 mmu_en = 1'b1;
    logic [NCH-1:0][31:0] lk_vaddr = '0;
    logic [NCH-1:0]       lk_hit;
    logic [NCH-1:0][31:0] lk_paddr;
    logic [NCH-1:0]       fill_valid = '0;
    logic [31:0]          fill_vaddr = '0;
    logic [31:0]          fill_paddr = '0;
    logic [1:0]           fill_size = '0;
    logic [1:0]           fill_dom = '0;
    logic                 fill_perm_ok = 1'b0;
    logic [NCH-1:0]       inval = '0;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    logic        m_val [NCH];
    logic [31:0] m_tag [NCH];
    logic [31:0] m_frm [NCH];
    logic [31:0] m_off [NCH];

    always #2.5 clk = ~clk;

    xlat_buf #(.NCH(NCH)) u0 (.*);

    function automatic logic [31:0] mask_of(int sz);
        int off;
        off = (sz == 0) ? 20 : (sz == 1) ? 16 : (sz == 2) ? 12 : 10;
        return 32'hFFFF_FFFF << off;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_ch(int c, string tag);
        logic        eh;
        logic [31:0] a;
        a  = lk_vaddr[c];
        eh = m_val[c] && ((a & ~m_off[c]) == m_tag[c]);
        chk(lk_hit[c] == eh, tag, {31'd0, lk_hit[c]}, {31'd0, eh});
        if (eh)
            chk(lk_paddr[c] == (m_frm[c] | (a & m_off[c])), tag,
                lk_paddr[c], m_frm[c] | (a & m_off[c]));
    endtask

    task automatic look_all(logic [31:0] a, string own, int fc, string other);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) lk_vaddr[c] = a;
        #1;
        for (int c = 0; c < NCH; c++) check_ch(c, (c == fc) ? own : other);
    endtask

    task automatic do_fill(int c, int sz, int dom, bit pok,
                           logic [31:0] va, logic [31:0] pa, bit inv);
        logic [31:0] m;
        @(negedge clk);
        fill_valid    = '0;
        fill_valid[c] = 1'b1;
        inval         = '0;
        inval[c]      = inv;
        fill_vaddr    = va;
        fill_paddr    = pa;
        fill_size     = 2'(sz);
        fill_dom      = 2'(dom);
        fill_perm_ok  = pok;
        lk_vaddr[c]   = va;
        #1;
        check_ch(c, "R8");
        @(posedge clk);
        m = mask_of(sz);
        if (inv) m_val[c] = 1'b0;
        else if (dom == 3 || (dom == 1 && pok)) begin
            m_val[c] = 1'b1;
            m_tag[c] = va & m;
            m_frm[c] = pa & m;
            m_off[c] = ~m;
        end
        @(negedge clk);
        fill_valid = '0;
        inval      = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < NCH; c++) m_val[c] = 1'b0;
    endtask

    initial begin
        int k;
        k = 0;
        for (int c = 0; c < NCH; c++) m_val[c] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: empty after reset
        look_all(32'h0000_0000, "R1", 0, "R1");
        look_all(32'h1234_5678, "R1", 0, "R1");

        // Sweep channels x sizes x domains x permission
        for (int c = 0; c < NCH; c++)
            for (int sz = 0; sz < 4; sz++)
                for (int dom = 0; dom < 4; dom++)
                    for (int p = 0; p < 2; p++) begin
                        logic [31:0] va, pa, m, one;
                        bit inv, ok;
                        k++;
                        va  = 32'h9E37_79B9 * k;
                        pa  = 32'h7F4A_7C15 * (k + 3);
                        m   = mask_of(sz);
                        one = ~m + 32'd1;
                        inv = ((k % 7) == 3) && (dom == 3);
                        ok  = (dom == 3) || (dom == 1 && p == 1);
                        do_fill(c, sz, dom, p[0], va, pa, inv);
                        look_all(va, inv ? "R6" : (ok ? "R2" : "R4"), c, "R5");
                        look_all(va ^ one, "R3", c, "R5");
                        look_all(va | ~m, "R2", c, "R5");
                        look_all(va & m, "R2", c, "R5");
                    end

        // R6: invalidate alone on channel 1
        do_fill(1, 2, 3, 1'b1, 32'hCAFE_1234, 32'h0BAD_0000, 1'b0);
        @(negedge clk);
        inval = 3'b010;
        @(posedge clk);
        m_val[1] = 1'b0;
        @(negedge clk);
        inval = '0;
        look_all(32'hCAFE_1234, "R6", 1, "R5");

        // R7: bypass
        @(negedge clk);
        mmu_en = 1'b0;
        for (int i = 0; i < 8; i++) begin
            logic [31:0] a;
            a = 32'hDEAD_BEEF ^ (32'h0101_0101 << i);
            for (int c = 0; c < NCH; c++) lk_vaddr[c] = a + c;
            #1;
            for (int c = 0; c < NCH; c++) begin
                chk(lk_hit[c] == 1'b1, "R7", {31'd0, lk_hit[c]}, 32'd1);
                chk(lk_paddr[c] == a + c, "R7", lk_paddr[c], a + c);
            end
            @(negedge clk);
        end
        mmu_en = 1'b1;

        // R1: reset again after mappings exist
        do_fill(0, 0, 3, 1'b0, 32'h4000_0000, 32'h8000_0000, 1'b0);
        do_reset();
        look_all(32'h4000_0000, "R1", 0, "R1");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule